// File: doc/BRIEF.md
# Eight-Channel Compare-Match Waveform Timer

A 16-bit base timer feeds eight compare channels. Each channel drives one output that holds a programmed starting level from the start of every timer period until the timer reaches the channel's compare value. From that point to the end of the period it drives the opposite level. This gives one pulse-width-modulated waveform per channel, all sharing one period. The period comes from one of three sources. The timer can run free over the full 16-bit range. It can restart after matching channel 0's compare value, in which case channel 0 acts only as the period setter. It can also restart after matching a separate period register. Each channel also has an inversion bit, an output-disable bit and a sticky match flag.

Software programs the block through a write-only port. Compare values, the period register and the mode selection go into shadow registers, which are copied into the working registers only at a period boundary or while counting is stopped. Level, inversion and disable bits act at once. The timer advances by one on each cycle where both `cnt_en` and the prescaled `tick` are high. When `cnt_en` is low, the timer is parked at zero.

Two small state machines set the behaviour. The timer machine has `TMR_HOLD` and `TMR_RUN`. It goes HOLD→RUN on the first edge with `cnt_en` high and RUN→HOLD on the first edge with `cnt_en` low. Each channel machine has `CH_LEAD` (starting level) and `CH_TRAIL` (opposite level). It goes LEAD→TRAIL on a counting edge that moves the timer onto the compare value. It goes TRAIL→LEAD, or straight back into TRAIL when the compare value is 0, at every period restart and on every parked cycle.

Top module: `cwt_timer_top`

## Requirements
- R1: The timer is 16 bits wide and advances only on a clock edge with both `cnt_en` and `tick` high. In free-running mode it counts 0000h to FFFFh, then returns to 0000h, giving a period of 65536 ticks.
- R2: While counting, channel j shows its starting level while the timer is below its compare value m and the opposite level once the timer is at or above m. With a low starting level in free-running mode, the output is high for 65536−m ticks of each period.
- R3: With mode field value 2, the timer climbs to n+1, where n is the period register, and then returns to 0000h. The period is n+2 ticks, and every channel, including 0, is high for n+2−m ticks (low starting level). When n is FFFFh, the period is 65536 ticks.
- R4: With mode field value 1, n is channel 0's compare value and the same n+2 period applies. Channel 0's output holds its starting level, after inversion, for the whole time. Channels 1 to 7 produce waveforms.
- R5: Mode field values 0 and 3 both give free-running operation.
- R6: A channel's match flag sets on a counting edge that moves the timer onto its compare value, including the move to 0000h at a restart. The flag then stays set. A write to the flag-clear address clears each flag whose data bit is 0 and leaves flags whose data bit is 1 unchanged. A match in the same cycle as a clear leaves the flag set.
- R7: Starting-level bit j set to 1 makes channel j start each period high.
- R8: Invert bit j set to 1 inverts channel j's final output.
- R9: Disable bit j set to 1 forces `wave_o[j]` to 0 whatever else is set.
- R10: A write to a compare value, the period register or the mode field while counting takes effect only at the next period restart. While `cnt_en` is low, such a write takes effect on the following clock edge.
- R11: One edge after `cnt_en` goes low, the timer is 0000h and every enabled output shows its starting level after inversion.
- R12: After reset, all outputs are 0 and all flags are clear, with level, invert, disable and mode all zero.
- R13: Write addresses (4 bits): 0–7 are compare values for channels 0–7; 8 is the period register; 9 is the mode field in data[1:0]; 10 is the starting levels (bit j is channel j); 11 is the invert bits; 12 is the disable bits; 13 is flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counting enable; low parks the timer at zero |
| tick | input | 1 | Prescaled count strobe |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| wave_o | output | 8 | Channel waveform outputs |
| match_flag_o | output | 8 | Sticky compare-match flags |

## Verification
A behavioural model in the bench tracks the counter as an integer and is compared with both output vectors on every cycle. Explicit checks count high cycles over whole periods, so a reset-on-match mode that restarts one tick early or late would show a high time off by one per period. A compare written mid-period is measured across the boundary; a design that applied it at once would give 12 high cycles instead of 17. Further checks cover the both-modes-selected case, which must not shorten the period, and a flag clear written in the exact cycle of a match, which a design with the wrong priority would lose. Channel 0 under reset-on-channel-0 is checked to stay at its starting level.

// File: rtl/cwt_pkg.sv
package cwt_pkg;

    typedef enum logic {
        TMR_HOLD = 1'b0,
        TMR_RUN  = 1'b1
    } tmr_state_t;

    typedef enum logic {
        CH_LEAD  = 1'b0,
        CH_TRAIL = 1'b1
    } ch_state_t;

    typedef enum logic [1:0] {
        PER_FREE = 2'd0,
        PER_CH0  = 2'd1,
        PER_REG  = 2'd2,
        PER_BOTH = 2'd3
    } per_sel_t;

    // register slots placed after the per-channel compare slots
    localparam int unsigned SLOT_PERIOD = 0;
    localparam int unsigned SLOT_MODE   = 1;
    localparam int unsigned SLOT_LEVEL  = 2;
    localparam int unsigned SLOT_INVERT = 3;
    localparam int unsigned SLOT_DISABL = 4;
    localparam int unsigned SLOT_CLEAR  = 5;
    localparam int unsigned SLOT_COUNT  = 6;

endpackage

// File: rtl/cwt_regs.sv
module cwt_regs
    import cwt_pkg::*;
#(
    parameter int unsigned NCH = 8,
    parameter int unsigned TW  = 16,
    parameter int unsigned AW  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [AW-1:0]           wr_addr,
    input  logic [TW-1:0]           wr_data,
    input  logic                    load,
    output logic [NCH-1:0][TW-1:0]  cmp_sh,
    output logic [NCH-1:0][TW-1:0]  cmp_act,
    output logic [TW-1:0]           per_act,
    output per_sel_t                mode_act,
    output logic [NCH-1:0]          lvl,
    output logic [NCH-1:0]          inv,
    output logic [NCH-1:0]          dis,
    output logic                    clr_we,
    output logic [NCH-1:0]          clr_mask
);

    localparam logic [AW-1:0] A_PER = AW'(NCH + SLOT_PERIOD);
    localparam logic [AW-1:0] A_MOD = AW'(NCH + SLOT_MODE);
    localparam logic [AW-1:0] A_LVL = AW'(NCH + SLOT_LEVEL);
    localparam logic [AW-1:0] A_INV = AW'(NCH + SLOT_INVERT);
    localparam logic [AW-1:0] A_DIS = AW'(NCH + SLOT_DISABL);
    localparam logic [AW-1:0] A_CLR = AW'(NCH + SLOT_CLEAR);

    logic [TW-1:0] per_sh;
    per_sel_t      mode_sh;

    // compare shadow and working copies, one slot per channel
    for (genvar j = 0; j < NCH; j++) begin : g_cmp
        localparam logic [AW-1:0] A_CMP = AW'(j);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp_sh[j] <= '1;
            end else if (wr_en && (wr_addr == A_CMP)) begin
                cmp_sh[j] <= wr_data;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cmp_act[j] <= '1;
            end else if (load) begin
                cmp_act[j] <= cmp_sh[j];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_sh  <= '1;
            mode_sh <= PER_FREE;
            lvl     <= '0;
            inv     <= '0;
            dis     <= '0;
        end else if (wr_en) begin
            if (wr_addr == A_PER) per_sh  <= wr_data;
            if (wr_addr == A_MOD) mode_sh <= per_sel_t'(wr_data[1:0]);
            if (wr_addr == A_LVL) lvl     <= wr_data[NCH-1:0];
            if (wr_addr == A_INV) inv     <= wr_data[NCH-1:0];
            if (wr_addr == A_DIS) dis     <= wr_data[NCH-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_act  <= '1;
            mode_act <= PER_FREE;
        end else if (load) begin
            per_act  <= per_sh;
            mode_act <= mode_sh;
        end
    end

    assign clr_we   = wr_en && (wr_addr == A_CLR);
    assign clr_mask = wr_data[NCH-1:0];

    AST_ACT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(cmp_act) && $stable(per_act) && $stable(mode_act))); // R10

endmodule

// File: rtl/cwt_base_timer.sv
module cwt_base_timer
    import cwt_pkg::*;
#(
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_en,
    input  logic          tick,
    input  logic          rst_mode,
    input  logic [TW-1:0] per_val,
    output logic [TW-1:0] cnt,
    output logic [TW-1:0] cnt_nxt,
    output logic          run,
    output logic          hold,
    output logic          step,
    output logic          restart
);

    tmr_state_t    st, st_nxt;
    logic [TW:0]   lim;
    logic          wrap;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= TMR_HOLD;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            TMR_HOLD: if (cnt_en)  st_nxt = TMR_RUN;
            TMR_RUN:  if (!cnt_en) st_nxt = TMR_HOLD;
            default:  st_nxt = TMR_HOLD;
        endcase
    end

    // outputs and counter datapath
    assign lim     = {1'b0, per_val} + {{TW{1'b0}}, 1'b1};
    assign wrap    = (cnt == {TW{1'b1}}) || (rst_mode && ({1'b0, cnt} == lim));
    assign hold    = !cnt_en;
    assign step    = cnt_en && tick;
    assign restart = step && wrap;
    assign run     = (st == TMR_RUN);

    always_comb begin
        if (hold)         cnt_nxt = '0;
        else if (restart) cnt_nxt = '0;
        else if (step)    cnt_nxt = cnt + {{(TW-1){1'b0}}, 1'b1};
        else              cnt_nxt = cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end

    AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_en |=> (cnt == '0) && !run); // R11
    AST_TICK_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !tick) |=> $stable(cnt)); // R1
    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (step && (cnt == {TW{1'b1}})) |=> (cnt == '0)); // R1
    AST_PERIOD_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rst_mode |-> ({1'b0, cnt} <= lim)); // R3

endmodule

// File: rtl/cwt_channel.sv
module cwt_channel
    import cwt_pkg::*;
#(
    parameter int unsigned TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          hold,
    input  logic          step,
    input  logic          restart,
    input  logic [TW-1:0] cnt_nxt,
    input  logic [TW-1:0] m_act,
    input  logic [TW-1:0] m_sh,
    input  logic          period_owner,
    input  logic          lvl,
    input  logic          inv,
    input  logic          dis,
    input  logic          clr_we,
    input  logic          clr_bit,
    output logic          wave,
    output logic          flag
);

    ch_state_t     st, st_nxt;
    logic          at_start;
    logic [TW-1:0] tgt;
    logic          eq;
    logic          hit;
    logic          level;

    assign at_start = hold || restart;
    assign tgt      = at_start ? m_sh : m_act;
    assign eq       = (cnt_nxt == tgt);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= CH_LEAD;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        hit    = 1'b0;
        unique case (st)
            CH_LEAD: begin
                if (at_start) begin
                    st_nxt = eq ? CH_TRAIL : CH_LEAD;
                    hit    = restart && eq;
                end else if (step && eq) begin
                    st_nxt = CH_TRAIL;
                    hit    = 1'b1;
                end
            end
            CH_TRAIL: begin
                if (at_start) begin
                    st_nxt = eq ? CH_TRAIL : CH_LEAD;
                    hit    = restart && eq;
                end
            end
            default: st_nxt = CH_LEAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  flag <= 1'b0;
        else if (hit)                flag <= 1'b1;
        else if (clr_we && !clr_bit) flag <= 1'b0;
    end

    // output process
    always_comb begin
        level = lvl;
        if (run && !period_owner && (st == CH_TRAIL)) level = !lvl;
        wave = dis ? 1'b0 : (level ^ inv);
    end

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(clr_we && !clr_bit)) |=> flag); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag); // R6
    AST_TRAIL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == CH_TRAIL) && !at_start) |=> (st == CH_TRAIL)); // R2

endmodule

// File: rtl/cwt_timer_top.sv
module cwt_timer_top
    import cwt_pkg::*;
#(
    parameter int unsigned NCH = 8,
    parameter int unsigned TW  = 16,
    parameter int unsigned AW  = $clog2(NCH + SLOT_COUNT)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cnt_en,
    input  logic            tick,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [TW-1:0]   wr_data,
    output logic [NCH-1:0]  wave_o,
    output logic [NCH-1:0]  match_flag_o
);

    logic [NCH-1:0][TW-1:0] cmp_sh;
    logic [NCH-1:0][TW-1:0] cmp_act;
    logic [TW-1:0]          per_act;
    per_sel_t               mode_act;
    logic [NCH-1:0]         lvl, inv, dis, clr_mask, owner;
    logic                   clr_we;
    logic                   rst_mode;
    logic [TW-1:0]          per_val;
    logic [TW-1:0]          cnt, cnt_nxt;
    logic                   run, hold, step, restart, load;

    assign load     = hold || restart;
    assign rst_mode = (mode_act == PER_CH0) || (mode_act == PER_REG);
    assign per_val  = (mode_act == PER_CH0) ? cmp_act[0] : per_act;

    cwt_regs #(.NCH(NCH), .TW(TW), .AW(AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .load     (load),
        .cmp_sh   (cmp_sh),
        .cmp_act  (cmp_act),
        .per_act  (per_act),
        .mode_act (mode_act),
        .lvl      (lvl),
        .inv      (inv),
        .dis      (dis),
        .clr_we   (clr_we),
        .clr_mask (clr_mask)
    );

    cwt_base_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt_en   (cnt_en),
        .tick     (tick),
        .rst_mode (rst_mode),
        .per_val  (per_val),
        .cnt      (cnt),
        .cnt_nxt  (cnt_nxt),
        .run      (run),
        .hold     (hold),
        .step     (step),
        .restart  (restart)
    );

    for (genvar j = 0; j < NCH; j++) begin : g_ch
        if (j == 0) begin : g_owner
            assign owner[j] = (mode_act == PER_CH0);
        end else begin : g_plain
            assign owner[j] = 1'b0;
        end

        cwt_channel #(.TW(TW)) u_ch (
            .clk          (clk),
            .rst_n        (rst_n),
            .run          (run),
            .hold         (hold),
            .step         (step),
            .restart      (restart),
            .cnt_nxt      (cnt_nxt),
            .m_act        (cmp_act[j]),
            .m_sh         (cmp_sh[j]),
            .period_owner (owner[j]),
            .lvl          (lvl[j]),
            .inv          (inv[j]),
            .dis          (dis[j]),
            .clr_we       (clr_we),
            .clr_bit      (clr_mask[j]),
            .wave         (wave_o[j]),
            .flag         (match_flag_o[j])
        );
    end

    AST_OWNER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_act == PER_CH0) && $stable(lvl[0]) && $stable(inv[0]) && $stable(dis[0])
         && $stable(mode_act)) |-> $stable(wave_o[0])); // R4

endmodule

// File: tb/cwt_timer_top_tb.sv
`timescale 1ns/1ps
module cwt_timer_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  wave_o;
    logic [7:0]  match_flag_o;

    always #2.5 clk = ~clk;

    cwt_timer_top dut_i (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .tick(tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wave_o(wave_o), .match_flag_o(match_flag_o)
    );

    int    nchk = 0;
    int    nfail = 0;
    bit    chk_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R12";

    // behavioural reference model
    int       mcnt;
    bit       mrun;
    int       sh_m[8];
    int       act_m[8];
    int       sh_n, act_n, sh_mode, act_mode;
    bit [7:0] mlvl, minv, mdis, mflag, mhit;
    int       mlim;
    bit       mrm;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcnt = 0; mrun = 0; sh_n = 65535; act_n = 65535;
            sh_mode = 0; act_mode = 0; mlvl = 0; minv = 0; mdis = 0; mflag = 0;
            for (int j = 0; j < 8; j++) begin sh_m[j] = 65535; act_m[j] = 65535; end
        end else begin
            mhit = 0;
            mrm  = (act_mode == 1) || (act_mode == 2);
            mlim = (act_mode == 1) ? act_m[0] : act_n;
            if (!cnt_en) begin
                mcnt = 0; act_n = sh_n; act_mode = sh_mode;
                for (int j = 0; j < 8; j++) act_m[j] = sh_m[j];
            end else if (tick) begin
                if (mcnt == 65535 || (mrm && mcnt == mlim + 1)) begin
                    mcnt = 0; act_n = sh_n; act_mode = sh_mode;
                    for (int j = 0; j < 8; j++) begin
                        act_m[j] = sh_m[j];
                        if (act_m[j] == 0) mhit[j] = 1'b1;
                    end
                end else begin
                    mcnt = mcnt + 1;
                    for (int j = 0; j < 8; j++) if (act_m[j] == mcnt) mhit[j] = 1'b1;
                end
            end
            mrun = cnt_en;
            if (wr_en && wr_addr == 4'd13) mflag = mflag & wr_data[7:0];
            mflag = mflag | mhit;
            if (wr_en) begin
                if (wr_addr < 4'd8) sh_m[wr_addr] = int'(wr_data);
                case (wr_addr)
                    4'd8:  sh_n = int'(wr_data);
                    4'd9:  sh_mode = int'(wr_data[1:0]);
                    4'd10: mlvl = wr_data[7:0];
                    4'd11: minv = wr_data[7:0];
                    4'd12: mdis = wr_data[7:0];
                    default: ;
                endcase
            end
        end
    end

    function automatic bit [7:0] exp_wave();
        bit [7:0] v;
        for (int j = 0; j < 8; j++) begin
            bit b;
            b = mlvl[j];
            if (mrun && !(act_mode == 1 && j == 0) && mcnt >= act_m[j]) b = ~b;
            v[j] = mdis[j] ? 1'b0 : (b ^ minv[j]);
        end
        return v;
    endfunction

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && chk_on && !done) begin
            nchk++;
            if (wave_o !== exp_wave() || match_flag_o !== mflag) begin
                nfail++;
                $display("FAIL %s model compare: wave=%h flags=%h expected wave=%h flags=%h",
                         cur_req, wave_o, match_flag_o, exp_wave(), mflag);
            end
        end
    end

    task automatic check(string req, int act, int expv, string what);
        nchk++;
        if (act != expv) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic count_hi(int n, output int h[8]);
        for (int j = 0; j < 8; j++) h[j] = 0;
        repeat (n) begin
            @(negedge clk);
            for (int j = 0; j < 8; j++) if (wave_o[j]) h[j]++;
        end
    endtask

    initial begin
        int h[8];
        idle(3);
        check("R12", int'(wave_o), 0, "outputs in reset");
        check("R12", int'(match_flag_o), 0, "flags in reset");
        rst_n = 1'b1;
        chk_on = 1'b1;
        idle(2);

        // free-running period and high time
        cur_req = "R13";
        wr(1, 16'hF000); wr(2, 0); wr(3, 16'h0010);
        idle(2);
        cur_req = "R2";
        cnt_en = 1'b1; tick = 1'b1;
        count_hi(65536, h);
        check("R2", h[1], 4096, "ch1 high ticks, m=F000h");
        check("R1", int'(wave_o[3]), 0, "ch3 back at period start");
        cur_req = "R1";
        tick = 1'b0;
        count_hi(30, h);
        check("R1", h[3], 0, "no advance without tick");

        // sticky flags and write-zero clear
        cur_req = "R6";
        check("R6", int'(match_flag_o), 8'hFF, "all flags after full period");
        wr(13, 16'h00F5);
        idle(1);
        check("R6", int'(match_flag_o), 8'hF5, "clear of bits written 0");
        wr(13, 16'h00FF);
        idle(1);
        check("R6", int'(match_flag_o), 8'hF5, "bits written 1 unchanged");

        // parked outputs
        cur_req = "R11";
        wr(10, 16'h0050); wr(11, 16'h0020); wr(12, 16'h0040);
        cnt_en = 1'b0;
        idle(3);
        check("R11", int'(wave_o), 8'h30, "parked level after inversion");

        // reset on period register
        cur_req = "R3";
        wr(8, 20); wr(9, 2); wr(0, 3); wr(2, 5); wr(4, 8); wr(5, 7);
        idle(2);
        cnt_en = 1'b1; tick = 1'b1;
        count_hi(66, h);
        check("R3", h[2], 51, "ch2 high over three n+2 periods");
        check("R3", h[0], 57, "ch0 waves in register mode");
        check("R7", h[4], 24, "ch4 starting high");
        check("R8", h[5], 21, "ch5 inverted");
        check("R9", h[6], 0, "ch6 disabled");

        // compare write mid-period waits for restart
        cur_req = "R10";
        while (mcnt != 3) @(negedge clk);
        wr(2, 10);
        count_hi(22, h);
        check("R10", h[2], 17, "old compare kept to period end");

        // reset on channel 0
        cur_req = "R4";
        cnt_en = 1'b0;
        wr(9, 1); wr(0, 12); wr(3, 4);
        idle(2);
        cnt_en = 1'b1;
        count_hi(28, h);
        check("R4", h[3], 20, "ch3 high over two periods of 14");
        check("R4", h[0], 0, "ch0 held at starting level");

        // both selections -> free-running, then set beats clear
        cur_req = "R5";
        cnt_en = 1'b0;
        wr(9, 3); wr(1, 40); wr(8, 20); wr(5, 150);
        idle(2);
        cnt_en = 1'b1;
        count_hi(100, h);
        check("R5", h[1], 61, "ch1 high, period not shortened");
        cur_req = "R6";
        while (mcnt != 149) @(negedge clk);
        wr(13, 0);
        idle(1);
        check("R6", int'(match_flag_o), 8'h20, "match wins over same-cycle clear");

        idle(4);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

endmodule